// File: doc/BRIEF.md
# Expansion Bus Card Select Decoder

This block decodes addresses and generates selects for one peripheral card on a 6502-style parallel expansion bus. It watches the CPU address, data and R/W lines and the phase-2 clock. It keeps a per-card view of a write-only select register that all cards share. From that view it produces chip selects for a 2 KB on-card ROM window, a page of card registers and an expansion register window. It also drives and senses a shared open-drain line that switches off the host's floating-point ROM.

A strapped 3-bit card ID picks which bit of the select register belongs to this card. Writes are captured on the falling edge of phase 2. All chip selects are combinational from the address and R/W, and are qualified by phase 2 being high.

The card has four states:
- `ST_IDLE`: the select register holds zero.
- `ST_OURS`: this card's bit is set.
- `ST_FOREIGN`: a non-zero value is held without this card's bit.
- `ST_SUBST`: no card is selected and the card is serving its own replacement floating-point ROM.

Transitions:
- Any select write moves the card to `ST_IDLE` (value zero), `ST_OURS` (own bit set) or `ST_FOREIGN` (any other non-zero value).
- `ST_IDLE` moves to `ST_SUBST` on a falling phase-2 edge when the replacement mode is armed and the shared line is high.
- Every other case holds the current state.

Top module: `card_select_decoder`

## Requirements
- R1: A write to $D1FF selects the card (state `ST_OURS`) when bit `card_id` of the written byte is 1. The ROM select is then active for reads from the very next bus cycle, so ID-byte reads at $D800/$D801 that follow the select write are served.
- R2: After reset, the card is deselected and the replacement mode is disarmed. A write of zero to $D1FF, or of a non-zero byte whose bit `card_id` is 0, deselects the card: no ROM, register or window select fires and `mpd_drive` is 0.
- R3: While the card is selected, a read with phase 2 high in $D800-$DFFF drives `rom_cs_n` low. In the same cycle `rom_addr` equals address bits 10..0. `mpd_drive` (1 = pull the shared active-low host-ROM-disable line low) is 1 for the whole time the card is selected.
- R4: `reg_cs_n` goes low for any access to $D100-$D1FE only while the card is selected. It never goes low for $D1FF.
- R5: `io_cs_n` goes low for any access to $D600-$D7FF only while the card is selected.
- R6: A write of a byte with bit 0 equal to 0 to $D100 while selected arms the replacement mode. A write with bit 0 equal to 1 disarms it. Writes to $D100 while not selected are ignored. When the mode is armed and $D1FF holds zero, the card enters `ST_SUBST` one bus cycle after the zero write. In `ST_SUBST` it drives `mpd_drive` and serves reads of $D800-$DFFF, but `reg_cs_n` stays high.
- R7: If the shared line (`mpd_in`, 0 = low) is low at a falling phase-2 edge in `ST_IDLE`, the card does not claim it: no drive and no ROM select. The card retries on every later cycle and claims the line on the first edge at which it is high.
- R8: A non-zero select write during `ST_SUBST` ends substitution. The line is released unless the write selects this card.
- R9: `dbus_oe` is 1 only for reads with phase 2 high that hit an active ROM window, card register or expansion window. Writes never assert `rom_cs_n`. All selects are inactive while phase 2 is low.
- R10: Reads, including reads of $D1FF, never change the selection state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| phi2 | input | 1 | Bus phase-2 clock; writes captured on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_id | input | 3 | Strapped card ID, selects a bit of the select byte |
| addr | input | 16 | CPU address bus |
| rw | input | 1 | 1 = read, 0 = write |
| data | input | 8 | CPU data bus as seen by the card |
| mpd_in | input | 1 | Sensed level of the shared host-ROM-disable line (0 = asserted) |
| rom_cs_n | output | 1 | Active-low on-card ROM select |
| rom_addr | output | 11 | ROM offset, address bits 10..0 |
| reg_cs_n | output | 1 | Active-low card register page select |
| io_cs_n | output | 1 | Active-low expansion window select |
| dbus_oe | output | 1 | Data bus output enable toward the CPU |
| mpd_drive | output | 1 | 1 = pull the shared host-ROM-disable line low |

## Verification
The assertions check the following on every falling phase-2 edge:
- a select write lands in the right state;
- ROM selects always come with the line drive;
- the select register never raises the register select;
- the bus is only driven on reads;
- the card never claims a line that another agent holds.

Only the bench scenarios can show the sequences:
- the sweep over every card ID and every select byte;
- that a $D100 write while deselected is ignored;
- the one-cycle gap before substitution starts;
- the release on a foreign select;
- the retry once an external pull goes away.

// File: rtl/cardsel_pkg.sv
package cardsel_pkg;

    localparam int BUS_AW = 16;
    localparam int BUS_DW = 8;

    localparam logic [BUS_AW-1:0] SEL_ADDR  = 16'hD1FF;
    localparam logic [BUS_AW-1:0] CTL_ADDR  = 16'hD100;
    localparam logic [BUS_AW-1:0] ROM_BASE  = 16'hD800;
    localparam logic [BUS_AW-1:0] IO_BASE   = 16'hD600;

    localparam int ROM_AW  = 11;
    localparam int IO_AW   = 9;
    localparam int PAGE_AW = 8;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SUBST   = 2'd1,
        ST_OURS    = 2'd2,
        ST_FOREIGN = 2'd3
    } card_state_e;

    typedef struct packed {
        logic sel_reg;
        logic ctl_reg;
        logic page_reg;
        logic rom_win;
        logic io_win;
    } addr_hit_t;

endpackage

// File: rtl/cardsel_addr_dec.sv
module cardsel_addr_dec
    import cardsel_pkg::*;
#(
    parameter int ADDR_W = BUS_AW,
    parameter int ROM_W  = ROM_AW,
    parameter int IO_W   = IO_AW,
    parameter int PAGE_W = PAGE_AW,
    parameter logic [ADDR_W-1:0] SEL_A  = SEL_ADDR,
    parameter logic [ADDR_W-1:0] CTL_A  = CTL_ADDR,
    parameter logic [ADDR_W-1:0] ROM_A  = ROM_BASE,
    parameter logic [ADDR_W-1:0] IO_A   = IO_BASE
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_hit_t         hit
);

    localparam int ROM_TW  = ADDR_W - ROM_W;
    localparam int IO_TW   = ADDR_W - IO_W;
    localparam int PAGE_TW = ADDR_W - PAGE_W;

    localparam logic [ROM_TW-1:0]  ROM_TAG  = ROM_A[ADDR_W-1:ROM_W];
    localparam logic [IO_TW-1:0]   IO_TAG   = IO_A[ADDR_W-1:IO_W];
    localparam logic [PAGE_TW-1:0] PAGE_TAG = SEL_A[ADDR_W-1:PAGE_W];

    always_comb begin
        hit          = '0;
        hit.sel_reg  = (addr == SEL_A);
        hit.ctl_reg  = (addr == CTL_A);
        hit.page_reg = (addr[ADDR_W-1:PAGE_W] == PAGE_TAG);
        hit.rom_win  = (addr[ADDR_W-1:ROM_W]  == ROM_TAG);
        hit.io_win   = (addr[ADDR_W-1:IO_W]   == IO_TAG);
    end

endmodule

// File: rtl/cardsel_fsm.sv
module cardsel_fsm
    import cardsel_pkg::*;
#(
    parameter int DATA_W = BUS_DW,
    localparam int ID_W  = $clog2(DATA_W)
) (
    input  logic              phi2,
    input  logic              rst_n,
    input  logic              rw,
    input  logic [DATA_W-1:0] data,
    input  logic [ID_W-1:0]   card_id,
    input  addr_hit_t         hit,
    input  logic              mpd_in,
    output card_state_e       state,
    output logic              sub_armed
);

    card_state_e state_nxt;
    card_state_e sel_target;
    logic        sel_wr;
    logic        ctl_wr;
    logic        fp_ctl;

    always_comb begin
        sel_wr = !rw && hit.sel_reg;
        ctl_wr = !rw && hit.ctl_reg && (state == ST_OURS);
        if (data == '0)
            sel_target = ST_IDLE;
        else if (data[card_id])
            sel_target = ST_OURS;
        else
            sel_target = ST_FOREIGN;
    end

    assign sub_armed = !fp_ctl;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (sel_wr)
                    state_nxt = sel_target;
                else if (sub_armed && mpd_in)
                    state_nxt = ST_SUBST;
            end
            ST_SUBST: begin
                if (sel_wr)
                    state_nxt = sel_target;
            end
            ST_OURS: begin
                if (sel_wr)
                    state_nxt = sel_target;
            end
            ST_FOREIGN: begin
                if (sel_wr)
                    state_nxt = sel_target;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(negedge phi2 or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            fp_ctl <= 1'b1;
        end else begin
            state <= state_nxt;
            if (ctl_wr)
                fp_ctl <= data[0];
        end
    end

endmodule

// File: rtl/cardsel_outputs.sv
module cardsel_outputs
    import cardsel_pkg::*;
#(
    parameter int ADDR_W = BUS_AW,
    parameter int ROM_W  = ROM_AW
) (
    input  logic              phi2,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  addr_hit_t         hit,
    input  card_state_e       state,
    output logic              rom_cs_n,
    output logic [ROM_W-1:0]  rom_addr,
    output logic              reg_cs_n,
    output logic              io_cs_n,
    output logic              dbus_oe,
    output logic              mpd_drive
);

    logic selected;
    logic serving;
    logic rom_cs;
    logic reg_cs;
    logic io_cs;

    always_comb begin
        selected = 1'b0;
        serving  = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_FOREIGN: ;
            ST_SUBST:   serving = 1'b1;
            ST_OURS: begin
                selected = 1'b1;
                serving  = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        rom_cs    = phi2 && rw && serving && hit.rom_win;
        reg_cs    = phi2 && selected && hit.page_reg && !hit.sel_reg;
        io_cs     = phi2 && selected && hit.io_win;
        rom_cs_n  = !rom_cs;
        reg_cs_n  = !reg_cs;
        io_cs_n   = !io_cs;
        dbus_oe   = phi2 && rw && (rom_cs || reg_cs || io_cs);
        mpd_drive = serving;
        rom_addr  = addr[ROM_W-1:0];
    end

endmodule

// File: rtl/card_select_decoder.sv
module card_select_decoder
    import cardsel_pkg::*;
#(
    parameter int ADDR_W = BUS_AW,
    parameter int DATA_W = BUS_DW,
    parameter int ROM_W  = ROM_AW,
    localparam int ID_W  = $clog2(DATA_W)
) (
    input  logic              phi2,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   card_id,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rw,
    input  logic [DATA_W-1:0] data,
    input  logic              mpd_in,
    output logic              rom_cs_n,
    output logic [ROM_W-1:0]  rom_addr,
    output logic              reg_cs_n,
    output logic              io_cs_n,
    output logic              dbus_oe,
    output logic              mpd_drive
);

    addr_hit_t   hit;
    card_state_e card_state;
    logic        sub_armed;

    cardsel_addr_dec #(
        .ADDR_W (ADDR_W),
        .ROM_W  (ROM_W)
    ) u_dec (
        .addr (addr),
        .hit  (hit)
    );

    cardsel_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .phi2      (phi2),
        .rst_n     (rst_n),
        .rw        (rw),
        .data      (data),
        .card_id   (card_id),
        .hit       (hit),
        .mpd_in    (mpd_in),
        .state     (card_state),
        .sub_armed (sub_armed)
    );

    cardsel_outputs #(
        .ADDR_W (ADDR_W),
        .ROM_W  (ROM_W)
    ) u_out (
        .phi2      (phi2),
        .rw        (rw),
        .addr      (addr),
        .hit       (hit),
        .state     (card_state),
        .rom_cs_n  (rom_cs_n),
        .rom_addr  (rom_addr),
        .reg_cs_n  (reg_cs_n),
        .io_cs_n   (io_cs_n),
        .dbus_oe   (dbus_oe),
        .mpd_drive (mpd_drive)
    );

endmodule

// File: rtl/cardsel_checker.sv
module cardsel_checker
    import cardsel_pkg::*;
#(
    parameter int DATA_W = BUS_DW,
    localparam int ID_W  = $clog2(DATA_W)
) (
    input logic              phi2,
    input logic              rst_n,
    input logic [ID_W-1:0]   card_id,
    input logic [BUS_AW-1:0] addr,
    input logic              rw,
    input logic [DATA_W-1:0] data,
    input logic              mpd_in,
    input logic              rom_cs_n,
    input logic              reg_cs_n,
    input logic              io_cs_n,
    input logic              dbus_oe,
    input logic              mpd_drive,
    input card_state_e       card_state
);

    AST_SEL_OWN_BIT: assert property (@(negedge phi2) disable iff (!rst_n)
        (!rw && addr == SEL_ADDR && data[card_id]) |=> (card_state == ST_OURS)); // R1

    AST_SEL_ZERO: assert property (@(negedge phi2) disable iff (!rst_n)
        (!rw && addr == SEL_ADDR && data == '0) |=> (card_state == ST_IDLE)); // R2

    AST_ROM_WITH_DRIVE: assert property (@(negedge phi2) disable iff (!rst_n)
        (!rom_cs_n) |-> mpd_drive); // R3

    AST_SEL_REG_NO_CS: assert property (@(negedge phi2) disable iff (!rst_n)
        (addr == SEL_ADDR) |-> reg_cs_n); // R4

    AST_IO_NEEDS_SEL: assert property (@(negedge phi2) disable iff (!rst_n)
        (!io_cs_n) |-> (card_state == ST_OURS)); // R5

    AST_NO_CLAIM_HELD: assert property (@(negedge phi2) disable iff (!rst_n)
        (card_state == ST_IDLE && !mpd_in) |=> (card_state != ST_SUBST)); // R7

    AST_SUBST_RELEASE: assert property (@(negedge phi2) disable iff (!rst_n)
        (card_state == ST_SUBST && !rw && addr == SEL_ADDR && data != '0 && !data[card_id])
        |=> !mpd_drive); // R8

    AST_OE_READ_ONLY: assert property (@(negedge phi2) disable iff (!rst_n)
        dbus_oe |-> rw); // R9

    AST_READ_KEEPS: assert property (@(negedge phi2) disable iff (!rst_n)
        (rw && card_state != ST_IDLE) |=> $stable(card_state)); // R10

endmodule

bind card_select_decoder cardsel_checker u_chk (
    .phi2       (phi2),
    .rst_n      (rst_n),
    .card_id    (card_id),
    .addr       (addr),
    .rw         (rw),
    .data       (data),
    .mpd_in     (mpd_in),
    .rom_cs_n   (rom_cs_n),
    .reg_cs_n   (reg_cs_n),
    .io_cs_n    (io_cs_n),
    .dbus_oe    (dbus_oe),
    .mpd_drive  (mpd_drive),
    .card_state (card_state)
);

// File: tb/sim_card_select_decoder.sv
`timescale 1ns/1ps
module sim_card_select_decoder;

    logic        phi2 = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  card_id = 3'd0;
    logic [15:0] addr = 16'h0000;
    logic        rw = 1'b1;
    logic [7:0]  data = 8'h00;
    logic        ext_pull = 1'b0;
    logic        mpd_in;
    logic        rom_cs_n;
    logic [10:0] rom_addr;
    logic        reg_cs_n;
    logic        io_cs_n;
    logic        dbus_oe;
    logic        mpd_drive;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 phi2 = ~phi2;

    assign mpd_in = ~(mpd_drive | ext_pull);

    card_select_decoder u0 (
        .phi2      (phi2),
        .rst_n     (rst_n),
        .card_id   (card_id),
        .addr      (addr),
        .rw        (rw),
        .data      (data),
        .mpd_in    (mpd_in),
        .rom_cs_n  (rom_cs_n),
        .rom_addr  (rom_addr),
        .reg_cs_n  (reg_cs_n),
        .io_cs_n   (io_cs_n),
        .dbus_oe   (dbus_oe),
        .mpd_drive (mpd_drive)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // one bus cycle; returns during phi2 high so outputs can be sampled
    task automatic cyc(input logic [15:0] a, input logic r, input logic [7:0] d);
        @(negedge phi2);
        #0.5;
        addr = a;
        rw   = r;
        data = d;
        @(posedge phi2);
        #1;
    endtask

    task automatic do_reset;
        @(negedge phi2);
        rst_n = 1'b0;
        #6;
        rst_n = 1'b1;
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge phi2);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            finish_run();
        end
    end

    initial begin
        // R2: reset state
        do_reset();
        cyc(16'hD800, 1'b1, 8'h00);
        chk("R2 reset rom_cs_n", rom_cs_n, 1);
        chk("R2 reset mpd_drive", mpd_drive, 0);
        chk("R2 reset dbus_oe", dbus_oe, 0);
        cyc(16'hD600, 1'b1, 8'h00);
        chk("R2 reset io_cs_n", io_cs_n, 1);

        // sweep over every ID and every select byte
        for (int id = 0; id < 8; id++) begin
            card_id = 3'(id);
            do_reset();
            for (int v = 0; v < 256; v++) begin
                logic        sel;
                logic [10:0] off;
                sel = v[id];
                off = 11'((v * 7 + id) % 2048);
                cyc(16'hD1FF, 1'b0, 8'(v));
                cyc(16'hD800 + 16'(off), 1'b1, 8'h00);
                chk("R1 rom_cs_n after select write", rom_cs_n, !sel);
                chk("R3 rom_addr", rom_addr, off);
                chk("R3 mpd_drive", mpd_drive, sel);
                chk("R9 dbus_oe on ROM read", dbus_oe, sel);
                cyc(16'hD1FF, 1'b1, 8'h00);
                chk("R4 select reg never reg_cs", reg_cs_n, 1);
                chk("R9 no oe on select reg", dbus_oe, 0);
                cyc(16'hD101 + 16'(v % 254), 1'b1, 8'h00);
                chk("R4 page reg_cs_n", reg_cs_n, !sel);
                cyc(16'hD600 + 16'((v * 2) % 512), 1'b1, 8'h00);
                chk("R5 io_cs_n", io_cs_n, !sel);
                cyc(16'hD801, 1'b0, 8'h55);
                chk("R9 write no rom_cs", rom_cs_n, 1);
                chk("R10 state kept by reads", mpd_drive, sel);
            end
        end

        // R9: selects inactive while phi2 low
        card_id = 3'd5;
        do_reset();
        cyc(16'hD1FF, 1'b0, 8'h20);
        cyc(16'hD800, 1'b1, 8'h00);
        chk("R1 selected id5", rom_cs_n, 0);
        @(negedge phi2);
        #1;
        chk("R9 rom_cs_n phi2 low", rom_cs_n, 1);
        chk("R9 dbus_oe phi2 low", dbus_oe, 0);

        // R6: substitution mode
        card_id = 3'd2;
        do_reset();
        cyc(16'hD100, 1'b0, 8'h00);          // ignored: not selected
        cyc(16'hD1FF, 1'b0, 8'h00);
        cyc(16'h0000, 1'b1, 8'h00);
        cyc(16'hD800, 1'b1, 8'h00);
        chk("R6 ctl write ignored when deselected", rom_cs_n, 1);
        chk("R6 ctl write ignored mpd", mpd_drive, 0);

        cyc(16'hD1FF, 1'b0, 8'h04);
        cyc(16'hD100, 1'b0, 8'h00);          // arm while selected
        cyc(16'hD1FF, 1'b0, 8'h00);
        cyc(16'hD800, 1'b1, 8'h00);          // IDLE this cycle
        chk("R6 gap cycle rom_cs_n", rom_cs_n, 1);
        chk("R6 gap cycle mpd", mpd_drive, 0);
        cyc(16'hD9AB, 1'b1, 8'h00);
        chk("R6 subst rom_cs_n", rom_cs_n, 0);
        chk("R6 subst rom_addr", rom_addr, 11'h1AB);
        chk("R6 subst mpd", mpd_drive, 1);
        chk("R6 subst oe", dbus_oe, 1);
        cyc(16'hD180, 1'b1, 8'h00);
        chk("R6 subst no reg_cs", reg_cs_n, 1);

        // R8: foreign select ends substitution
        cyc(16'hD1FF, 1'b0, 8'h01);
        cyc(16'hD800, 1'b1, 8'h00);
        chk("R8 released mpd", mpd_drive, 0);
        chk("R8 released rom", rom_cs_n, 1);

        // R7: lockout while another agent holds the line
        ext_pull = 1'b1;
        cyc(16'hD1FF, 1'b0, 8'h00);
        for (int k = 0; k < 4; k++) begin
            cyc(16'hD800, 1'b1, 8'h00);
            chk("R7 lockout rom", rom_cs_n, 1);
            chk("R7 lockout drive", mpd_drive, 0);
        end
        ext_pull = 1'b0;
        cyc(16'hD800, 1'b1, 8'h00);
        chk("R7 claim after release", rom_cs_n, 0);
        chk("R7 drive after release", mpd_drive, 1);

        // R8: own select during substitution keeps the line
        cyc(16'hD1FF, 1'b0, 8'h04);
        cyc(16'hD180, 1'b1, 8'h00);
        chk("R8 own select reg_cs", reg_cs_n, 0);
        chk("R8 own select mpd", mpd_drive, 1);

        // R6: disarm
        cyc(16'hD100, 1'b0, 8'h01);
        cyc(16'hD1FF, 1'b0, 8'h00);
        cyc(16'h0000, 1'b1, 8'h00);
        cyc(16'hD800, 1'b1, 8'h00);
        chk("R6 disarmed rom", rom_cs_n, 1);
        chk("R6 disarmed mpd", mpd_drive, 0);

        // R10: read of select reg while selected changes nothing
        cyc(16'hD1FF, 1'b0, 8'h04);
        cyc(16'hD1FF, 1'b1, 8'h00);
        cyc(16'hD800, 1'b1, 8'h00);
        chk("R10 read keeps selection", rom_cs_n, 0);

        done = 1'b1;
        finish_run();
    end

endmodule